// File: doc/BRIEF.md
# Tick-Driven Watchdog with Reset Steering

This block supervises software by counting down a timeout on a slow time base, a one-cycle tick that arrives sixteen times per second. Software programs one control byte. The byte holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout in ticks is the multiplier times four raised to the resolution code. Writing the control byte restarts the countdown, and so does reading it back. Software keeps the watchdog quiet by touching the control register more often than the timeout.

When the countdown runs out, a sticky timeout flag is raised. The steering bit then picks the action. With steering set, the block pulses a reset request for one cycle, clears the control register and clears a century bit that it holds. With steering clear, the block pulses an interrupt for one cycle and keeps the control register. After an expiry the count stays stopped until software re-arms it.

The registers sit behind a byte-wide port with a 2-bit address and a combinational read path.

Top module: `wdog_reset_steer`

## Requirements
- R1: After reset the flags register (address 0), the control register (address 1) and the century register (address 2) all read 0x00, address 3 always reads 0x00, and neither pulse output is high.
- R2: The control byte holds steering in bit 7, the multiplier in bits 6:2 and the resolution code in bits 1:0. After the control register is armed, expiry happens on tick number multiplier × 4^resolution, counted from the arming.
- R3: A control value of 0x00 disables the watchdog: no expiry, no pulse, no flag.
- R4: A multiplier of zero with a non-zero resolution code also disables the watchdog.
- R5: A write to address 1 stores the byte, clears flags bit 7 and restarts the countdown from the new value.
- R6: A read of address 1 returns the stored byte and restarts the countdown from it, without changing the flags.
- R7: On expiry, bit 7 of the flags register becomes 1 and stays 1 until the next write to address 1.
- R8: On expiry with steering set, rst_req_o is high for exactly one cycle and irq_o stays low. The control register becomes 0x00 and century bit 6 becomes 0.
- R9: On expiry with steering clear, irq_o is high for exactly one cycle and rst_req_o stays low. The control register keeps its value.
- R10: Writes to address 0 have no effect on the flags register.
- R11: After an expiry no further pulse occurs, however many ticks follow, until the watchdog is re-armed.
- R12: The century register at address 2 stores only bit 6 of a write. Its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle 16 Hz time-base pulse |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select: 0 flags, 1 control, 2 century, 3 spare |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| rst_req_o | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench builds the block with its default parameters: a 5-bit multiplier and a 2-bit resolution code, which give an 11-bit countdown. That reach covers every timeout from a single tick up to the largest, 1984 ticks. The bench exercises four resolution codes from 0 to 3 and checks each expiry on its exact tick edge, one tick early and on the tick itself. It also drives both steering choices, both disabled encodings, and restarts by write and by read placed partway through a countdown.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_ADDR_W = 2;
  localparam int MULT_W     = 5;
  localparam int RES_W      = 2;
  localparam int FLAG_BIT   = 7;
  localparam int CENT_BIT   = 6;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_FLAGS = 2'd0,
    REG_WDOG  = 2'd1,
    REG_CENT  = 2'd2,
    REG_SPARE = 2'd3
  } wdog_reg_e;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic [CNT_W-1:0]  interval_o
);
  localparam int NRES = 1 << RES_W;

  logic [CNT_W-1:0] scaled [NRES];

  // one scaled copy of the multiplier per resolution code (x4 per step)
  for (genvar k = 0; k < NRES; k++) begin : g_scale
    assign scaled[k] = CNT_W'(mult_i) << (2 * k);
  end

  assign interval_o = scaled[res_i];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  // clock enable: a restart, or a tick while counting
  assign cnt_en = arm_i | (armed_q & tick_i);

  always_comb begin
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    expire_o = 1'b0;
    if (arm_i) begin
      cnt_d   = load_i;
      armed_d = (load_i != '0);
    end else if (armed_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        expire_o = 1'b1;
        armed_d  = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  expire_i,
  output logic [BYTE_W-1:0]     rdata_o,
  output logic                  arm_o,
  output wdog_ctrl_t            arm_val_o,
  output wdog_ctrl_t            ctrl_o,
  output logic                  flag_o,
  output logic                  irq_o,
  output logic                  rst_req_o
);
  wdog_ctrl_t ctrl_q, ctrl_d;
  logic       flag_q, flag_d;
  logic       cent_q, cent_d;
  logic       irq_q, rst_q;
  logic       wr_wdog, rd_wdog, wr_cent;
  logic       ctrl_en, flag_en, cent_en;
  logic       exp_reset, exp_irq;

  assign wr_wdog = req_i &  we_i & (addr_i == REG_WDOG);
  assign rd_wdog = req_i & ~we_i & (addr_i == REG_WDOG);
  assign wr_cent = req_i &  we_i & (addr_i == REG_CENT);

  assign exp_reset = expire_i &  ctrl_q.steer;
  assign exp_irq   = expire_i & ~ctrl_q.steer;

  assign arm_o     = wr_wdog | rd_wdog;
  assign arm_val_o = wr_wdog ? wdog_ctrl_t'(wdata_i) : ctrl_q;

  assign ctrl_en = wr_wdog | exp_reset;
  assign flag_en = wr_wdog | expire_i;
  assign cent_en = wr_cent | exp_reset;

  always_comb begin
    ctrl_d = wr_wdog ? wdog_ctrl_t'(wdata_i) : '0;
    flag_d = ~wr_wdog;
    cent_d = wr_cent ? wdata_i[CENT_BIT] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cent_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (flag_en) flag_q <= flag_d;
      if (cent_en) cent_q <= cent_d;
      irq_q <= exp_irq;
      rst_q <= exp_reset;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_FLAGS: rdata_o[FLAG_BIT] = flag_q;
      REG_WDOG:  rdata_o           = ctrl_q;
      REG_CENT:  rdata_o[CENT_BIT] = cent_q;
      default:   rdata_o           = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog_reset_steer.sv
module wdog_reset_steer
  import wdog_pkg::*;
#(
  parameter int MULT_W_P = wdog_pkg::MULT_W,
  parameter int RES_W_P  = wdog_pkg::RES_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  output logic [BYTE_W-1:0]     rdata_o,
  output logic                  irq_o,
  output logic                  rst_req_o
);
  localparam int CNT_W = MULT_W_P + 2 * ((1 << RES_W_P) - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             arm_w, expire_w, armed_w, flag_w;
  wdog_ctrl_t       arm_val_w, ctrl_s;
  logic [BYTE_W-1:0] ctrl_w;
  logic [CNT_W-1:0] interval_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  wdog_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .expire_i  (expire_w),
    .rdata_o   (rdata_o),
    .arm_o     (arm_w),
    .arm_val_o (arm_val_w),
    .ctrl_o    (ctrl_s),
    .flag_o    (flag_w),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  assign ctrl_w = ctrl_s;

  wdog_interval #(
    .MULT_W (MULT_W_P),
    .RES_W  (RES_W_P),
    .CNT_W  (CNT_W)
  ) u_interval (
    .mult_i     (arm_val_w.mult),
    .res_i      (arm_val_w.res),
    .interval_o (interval_w)
  );

  wdog_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .arm_i    (arm_w),
    .load_i   (interval_w),
    .tick_i   (tick_i),
    .expire_o (expire_w),
    .armed_o  (armed_w)
  );
endmodule

// File: rtl/wdog_reset_steer_chk.sv
module wdog_reset_steer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       flag_q,
  input logic [7:0] ctrl_q,
  input logic       armed
);
  // R8
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));

  // R9
  irq_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R8
  rst_clears_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (ctrl_q == 8'h00));

  // R7
  pulse_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |-> flag_q);

  // R11
  pulse_needs_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |-> $past(armed));

  // R5
  write_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd1) |=> !flag_q);
endmodule

bind wdog_reset_steer wdog_reset_steer_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_n),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .flag_q    (flag_w),
  .ctrl_q    (ctrl_w),
  .armed     (armed_w)
);

// File: tb/wdog_reset_steer_tb_top.sv
module wdog_reset_steer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o, rst_req_o;

  int n_checks = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int rst_cnt = 0;
  int ticks_sent = 0;
  int irq_tick = -1;

  always #10 clk_i = ~clk_i;   // 50 MHz

  wdog_reset_steer dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (irq_o) begin
      irq_cnt  = irq_cnt + 1;
      irq_tick = ticks_sent;
    end
    if (rst_req_o) rst_cnt = rst_cnt + 1;
  end

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      ticks_sent++;
      @(negedge clk_i);
      tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk_i);
    irq_cnt = 0; rst_cnt = 0; ticks_sent = 0; irq_tick = -1;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    bus_read(2'd0, d); check("R1 flags", d, 8'h00);
    bus_read(2'd1, d); check("R1 ctrl", d, 8'h00);
    bus_read(2'd2, d); check("R1 century", d, 8'h00);
    bus_read(2'd3, d); check("R1 spare", d, 8'h00);
    check("R1 irq low", irq_o, 0);
    check("R1 rst low", rst_req_o, 0);
  endtask

  task automatic t_irq_mode();
    logic [7:0] d;
    bus_write(2'd1, 8'h05);       // mult 1, res 1 -> 4 ticks
    clear_counts();
    give_ticks(3);
    check("R2 no early expiry", irq_cnt, 0);
    give_ticks(1);
    check("R9 one irq cycle", irq_cnt, 1);
    check("R2 expiry tick", irq_tick, 4);
    check("R9 no reset", rst_cnt, 0);
    give_ticks(12);
    check("R11 stopped after expiry", irq_cnt, 1);
    bus_read(2'd0, d); check("R7 flag set", d, 8'h80);
    bus_read(2'd1, d); check("R9 ctrl kept", d, 8'h05);
  endtask

  task automatic t_write_restart();
    logic [7:0] d;
    bus_write(2'd1, 8'h09);       // mult 2, res 1 -> 8 ticks
    bus_read(2'd0, d); check("R5 write clears flag", d, 8'h00);
    clear_counts();
    give_ticks(5);
    bus_write(2'd1, 8'h09);
    give_ticks(7);
    check("R5 write restarts", irq_cnt, 0);
    give_ticks(1);
    check("R5 expiry after restart", irq_cnt, 1);
  endtask

  task automatic t_read_restart();
    logic [7:0] d;
    bus_write(2'd1, 8'h0C);       // mult 3, res 0 -> 3 ticks
    clear_counts();
    give_ticks(2);
    bus_read(2'd1, d); check("R6 read value", d, 8'h0C);
    give_ticks(2);
    check("R6 read restarts", irq_cnt, 0);
    give_ticks(1);
    check("R6 expiry after read", irq_cnt, 1);
    bus_read(2'd1, d);
    bus_read(2'd0, d); check("R6 read keeps flag", d, 8'h80);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    bus_write(2'd1, 8'h00);
    clear_counts();
    give_ticks(40);
    check("R3 zero disables", irq_cnt + rst_cnt, 0);
    bus_write(2'd1, 8'h03);       // mult 0, res 3
    give_ticks(40);
    check("R4 zero mult disables", irq_cnt + rst_cnt, 0);
    bus_read(2'd0, d); check("R4 flag stays clear", d, 8'h00);
  endtask

  task automatic t_reset_mode();
    logic [7:0] d;
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, d); check("R12 century bit only", d, 8'h40);
    bus_write(2'd1, 8'h85);       // steer, mult 1, res 1 -> 4 ticks
    clear_counts();
    give_ticks(3);
    check("R8 no early reset", rst_cnt, 0);
    give_ticks(1);
    check("R8 one reset cycle", rst_cnt, 1);
    check("R8 no irq", irq_cnt, 0);
    bus_read(2'd0, d); check("R7 flag after reset", d, 8'h80);
    bus_read(2'd2, d); check("R8 century cleared", d, 8'h00);
    bus_read(2'd1, d); check("R8 ctrl cleared", d, 8'h00);
    give_ticks(20);
    check("R11 no pulse after reset", rst_cnt + irq_cnt, 1);
  endtask

  task automatic t_flags_ro();
    logic [7:0] d;
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d); check("R10 write 0 ignored", d, 8'h80);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, d); check("R10 write FF ignored", d, 8'h00);
  endtask

  task automatic t_long_intervals();
    bus_write(2'd1, 8'h0A);       // mult 2, res 2 -> 32 ticks
    clear_counts();
    give_ticks(31);
    check("R2 res2 early", irq_cnt, 0);
    give_ticks(1);
    check("R2 res2 expiry", irq_cnt, 1);
    bus_write(2'd1, 8'h7F);       // mult 31, res 3 -> 1984 ticks
    clear_counts();
    give_ticks(1983);
    check("R2 res3 early", irq_cnt, 0);
    give_ticks(1);
    check("R2 res3 expiry", irq_cnt, 1);
    check("R2 res3 tick", irq_tick, 1984);
  endtask

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset_state();
    t_irq_mode();
    t_write_restart();
    t_read_restart();
    t_disabled();
    t_reset_mode();
    t_flags_ro();
    t_long_intervals();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule